// File: doc/BRIEF.md
# UART Line-Control Busy Guard

This block is the register-access front end of a 16550-style UART. It decodes a 32-bit APB-like bus, has four 8-bit registers on word boundaries, and protects the line control register from changes while the serial engine is active. The serial engine itself is not part of the block. A single `busy_i` input stands in for it, and a scratch register stands in for the other storage.

A write to the line control register made while `busy_i` is high is dropped. The dropped write records a busy-detect event. That event drives `irq_o` and appears as a code in the interrupt identification register. Software reads the status register to clear the event. It then reads the line control register back to confirm whether its write was accepted.

A transfer happens in every cycle where `psel` and `penable` are both high. There are no wait states and no back-pressure, so consecutive transfer cycles are allowed. Read data is combinational during the transfer cycle.

Top module: `uart_busy_guard`

## Requirements
- R1: The byte address is the register index shifted left by two, and `paddr[1:0]` is ignored. The register map is: interrupt identification at index 2 (0x08), line control at index 3 (0x0C), scratch at index 7 (0x1C) and status at index 0x1F (0x7C). Any other address reads 0.
- R2: Only bits 7:0 of each slot are used. `prdata[31:8]` reads 0, and `pwdata[31:8]` is ignored on writes.
- R3: The status register reads `busy_i` in bit 0 and 0 in bits 7:1.
- R4: A line control write while `busy_i` is low updates the register at the edge that ends the transfer, and it reads back in the next transfer. Such a write raises no interrupt.
- R5: A line control write while `busy_i` is high leaves the register unchanged.
- R6: A blocked line control write sets `irq_o` from the edge that ends the transfer. While the interrupt is pending, the identification register reads 0x07.
- R7: With no interrupt pending, the identification register reads 0x01, where bit 0 = 1 means none pending.
- R8: A status read clears the pending interrupt, and `irq_o` is low after the edge that ends that read.
- R9: A blocked write's event takes effect one cycle after the write. If a status read lands in that same cycle (the transfer right after the blocked write), the new event wins and the interrupt stays pending.
- R10: After reset, line control and scratch read 0 and no interrupt is pending.
- R11: The scratch register stores its 8 bits whatever the state of `busy_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Transfer phase; a transfer happens when this and psel are high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the transfer cycle |
| busy_i | input | 1 | Serial engine active |
| irq_o | output | 1 | Busy-detect interrupt pending |

## Verification
A status read that clears the interrupt and a freshly blocked line control write that sets it can meet in the same cycle. The registered event from the write arrives in the same cycle as the clearing read. The bench sets this up with two back-to-back transfers: a blocked line control write, then a status read in the next cycle. It requires `irq_o` to stay high after the read, and a second, isolated status read must then clear it. The table-driven part covers the same set and clear paths separately, with idle cycles between them.

// File: rtl/uart_guard_pkg.sv
package uart_guard_pkg;
  localparam int NUM_SLOTS = 4;
  // slot order used by the decoder hit vector
  localparam int SLOT_IIR = 0;
  localparam int SLOT_LCR = 1;
  localparam int SLOT_SCR = 2;
  localparam int SLOT_USR = 3;
  // register index of each slot (byte address = index << 2)
  localparam int SLOT_INDEX [NUM_SLOTS] = '{2, 3, 7, 31};
  localparam logic [7:0] IIR_NONE = 8'h01;
  localparam logic [7:0] IIR_BUSY = 8'h07;
endpackage

// File: rtl/ug_addr_decode.sv
module ug_addr_decode
  import uart_guard_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_SLOTS-1:0] hit
);
  localparam int IDX_W = ADDR_W - 2;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign hit[s] = (addr[ADDR_W-1:2] == IDX_W'(SLOT_INDEX[s]));
  end
endmodule

// File: rtl/ug_lcr_guard.sv
module ug_lcr_guard #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             busy,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] lcr,
  output logic             blocked
);
  assign blocked = wr_en & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lcr <= '0;
    else if (wr_en && !busy) lcr <= wdata;
  end
endmodule

// File: rtl/ug_busy_irq.sv
module ug_busy_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic blocked,
  input  logic clr_rd,
  output logic evt_q,
  output logic pend_q,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      evt_q  <= blocked;
      // a landing event outranks a clearing read
      pend_q <= evt_q | (pend_q & ~clr_rd);
    end
  end

  assign pending = evt_q | pend_q;
endmodule

// File: rtl/uart_busy_guard.sv
module uart_busy_guard
  import uart_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              busy_i,
  output logic              irq_o
);
  logic                 xfer;
  logic [NUM_SLOTS-1:0] hit;
  logic [REG_W-1:0]     lcr_q, scr_q, rd_byte;
  logic                 blocked, evt_q, pend_q;

  assign xfer = psel & penable;

  ug_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (paddr),
    .hit  (hit)
  );

  ug_lcr_guard #(.REG_W(REG_W)) u_lcr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (xfer & pwrite & hit[SLOT_LCR]),
    .busy    (busy_i),
    .wdata   (pwdata[REG_W-1:0]),
    .lcr     (lcr_q),
    .blocked (blocked)
  );

  ug_busy_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .blocked (blocked),
    .clr_rd  (xfer & ~pwrite & hit[SLOT_USR]),
    .evt_q   (evt_q),
    .pend_q  (pend_q),
    .pending (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               scr_q <= '0;
    else if (xfer && pwrite && hit[SLOT_SCR]) scr_q <= pwdata[REG_W-1:0];
  end

  always_comb begin
    rd_byte = '0;
    if (hit[SLOT_IIR])      rd_byte = irq_o ? REG_W'(IIR_BUSY) : REG_W'(IIR_NONE);
    else if (hit[SLOT_LCR]) rd_byte = lcr_q;
    else if (hit[SLOT_SCR]) rd_byte = scr_q;
    else if (hit[SLOT_USR]) rd_byte = REG_W'(busy_i);
    prdata = (xfer && !pwrite) ? DATA_W'(rd_byte) : '0;
  end
endmodule

// File: rtl/uart_busy_guard_chk.sv
module uart_busy_guard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              busy_i,
  input logic              irq_o,
  input logic [REG_W-1:0]  lcr_q,
  input logic              evt_q
);
  logic wr_lcr, rd_usr, rd_iir;
  assign wr_lcr = psel & penable & pwrite & (paddr[ADDR_W-1:2] == (ADDR_W-2)'(3));
  assign rd_usr = psel & penable & ~pwrite & (paddr[ADDR_W-1:2] == (ADDR_W-2)'(31));
  assign rd_iir = psel & penable & ~pwrite & (paddr[ADDR_W-1:2] == (ADDR_W-2)'(2));

  p_lcr_take_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lcr && !busy_i) |=> lcr_q == $past(pwdata[REG_W-1:0]));
  p_lcr_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lcr && busy_i) |=> $stable(lcr_q));
  p_irq_on_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lcr && busy_i) |=> irq_o);
  p_iir_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && irq_o) |-> prdata == DATA_W'(8'h07));
  p_iir_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && !irq_o) |-> prdata == DATA_W'(8'h01));
  p_usr_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_usr |-> prdata == DATA_W'(busy_i));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_usr && !evt_q) |=> !irq_o);
  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_usr && evt_q) |=> irq_o);
endmodule

bind uart_busy_guard uart_busy_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .busy_i(busy_i),
  .irq_o(irq_o), .lcr_q(lcr_q), .evt_q(evt_q)
);

// File: tb/uart_busy_guard_bench.sv
module uart_busy_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, busy_i = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_o;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  uart_busy_guard u_uart_busy_guard (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .busy_i(busy_i), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic        busy;
    logic [7:0]  exp;
    logic        irq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h0C, 32'h0000001B, 1'b0, 8'h00, 1'b0}, // R4 idle LCR write
    '{1'b0, 8'h0C, 32'h0,        1'b0, 8'h1B, 1'b0}, // R4 read back
    '{1'b1, 8'h1C, 32'hFFFFFFA5, 1'b1, 8'h00, 1'b0}, // R11 scratch while busy
    '{1'b0, 8'h1C, 32'h0,        1'b1, 8'hA5, 1'b0}, // R11 / R2
    '{1'b0, 8'h7C, 32'h0,        1'b1, 8'h01, 1'b0}, // R3 busy
    '{1'b0, 8'h7C, 32'h0,        1'b0, 8'h00, 1'b0}, // R3 idle
    '{1'b0, 8'h08, 32'h0,        1'b0, 8'h01, 1'b0}, // R7
    '{1'b1, 8'h0C, 32'h00000080, 1'b1, 8'h00, 1'b1}, // R6 blocked write
    '{1'b0, 8'h0C, 32'h0,        1'b1, 8'h1B, 1'b1}, // R5 unchanged
    '{1'b0, 8'h08, 32'h0,        1'b1, 8'h07, 1'b1}, // R6 code
    '{1'b0, 8'h7C, 32'h0,        1'b0, 8'h00, 1'b0}, // R8 clear
    '{1'b0, 8'h08, 32'h0,        1'b0, 8'h01, 1'b0}, // R7 after clear
    '{1'b1, 8'h0C, 32'hFFFFFF47, 1'b0, 8'h00, 1'b0}, // R2 upper bits ignored
    '{1'b0, 8'h0E, 32'h0,        1'b0, 8'h47, 1'b0}, // R1 low address bits ignored
    '{1'b0, 8'h40, 32'h0,        1'b0, 8'h00, 1'b0}  // R1 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the next negedge with irq sampled after the edge
  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                      input logic b, output logic [31:0] rd, output logic irq_after);
    psel = 1'b1; penable = 1'b1; pwrite = wr; paddr = a; pwdata = wd; busy_i = b;
    #5 rd = prdata;
    @(negedge clk);
    irq_after = irq_o;
  endtask

  task automatic idle();
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic        irq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq", {31'b0, irq_o}, 32'h0);
    xfer(1'b0, 8'h0C, 32'h0, 1'b0, rd, irq); check("R10 lcr", rd, 32'h0); idle();
    xfer(1'b0, 8'h1C, 32'h0, 1'b0, rd, irq); check("R10 scr", rd, 32'h0); idle();
    xfer(1'b0, 8'h08, 32'h0, 1'b0, rd, irq); check("R10 iir", rd, 32'h1); idle();

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].addr, VECS[i].wd, VECS[i].busy, rd, irq);
      if (!VECS[i].wr) check($sformatf("vec%0d data", i), rd, {24'b0, VECS[i].exp});
      check($sformatf("vec%0d irq", i), {31'b0, irq}, {31'b0, VECS[i].irq});
      idle();
    end

    // R9 blocked write then status read in the very next cycle
    xfer(1'b1, 8'h0C, 32'h000000EE, 1'b1, rd, irq);
    check("R6 irq after block", {31'b0, irq}, 32'h1);
    xfer(1'b0, 8'h7C, 32'h0, 1'b1, rd, irq);
    check("R3 usr in conflict", rd, 32'h1);
    check("R9 event wins over clear", {31'b0, irq}, 32'h1);
    idle(); idle();
    check("R9 still pending", {31'b0, irq_o}, 32'h1);
    xfer(1'b0, 8'h0C, 32'h0, 1'b0, rd, irq);
    check("R5 lcr kept", rd, 32'h47);
    idle();
    xfer(1'b0, 8'h7C, 32'h0, 1'b0, rd, irq);
    check("R8 later clear", {31'b0, irq}, 32'h0);
    idle();
    // R4 idle write then back-to-back readback
    xfer(1'b1, 8'h0C, 32'h0000005A, 1'b0, rd, irq);
    xfer(1'b0, 8'h0C, 32'h0, 1'b0, rd, irq);
    check("R4 back-to-back readback", rd, 32'h5A);
    check("R4 no irq", {31'b0, irq}, 32'h0);
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule